// File: doc/BRIEF.md
# Floating-Point Class Tester

This block reads a 64-bit word and sorts it into IEEE-754 value classes. For each lane it returns a compact 4-bit type code. Bit 0 is the sign. Bit 1 says whether the mantissa field is nonzero. Bits 3..2 say whether the exponent is all zeros, all ones, or some other value. Reading the three fields together gives zero, denormal, infinity, NaN or normal, each with its sign. Software can build classify, is-finite, is-infinite, is-NaN, is-normal and sign-bit tests from this code with a mask and a compare.

A 2-bit size code selects the format: 00 means single precision and 01 means double precision. A lane-split flag applies only to single precision; when it is set, the upper and lower 32-bit halves are classified independently. Each lane's code is zero-extended to the width of that lane. The classification logic is purely combinational. A parameter places a register on the result, and by default that register is present. The block never signals an exception. The one exception to normal operation is a reserved size code, which gives an all-zero result and raises a flag.

Top module: `fpClassTester`

## Requirements
- R1: Bit 0 of every active lane code equals that lane's sign bit: bit 63 for double precision, bit 31 for the low single lane, and bit 63 for the upper single lane.
- R2: Bit 1 of a lane code is 1 when that lane's mantissa field is nonzero and 0 when it is zero. The mantissa field is bits 51..0 in double precision and bits 22..0 in each single lane.
- R3: Lane code bits 3..2 are 00 when the exponent field is all zeros and 01 when it is all ones. The exponent field is bits 62..52 for double precision and bits 30..23 in each single lane.
- R4: Any other exponent value gives lane code bits 3..2 = 10. This holds at both edges of the normal range.
- R5: All result bits above a lane's 4-bit code are 0: bits 63..36 and 31..4 always, and bits 35..32 whenever the upper single lane is inactive.
- R6: Size code 01 gives one double lane in result bits 3..0, and the lane-split flag has no effect.
- R7: Size code 00 with the lane-split flag clear classifies only input bits 31..0. The input bits 63..32 have no effect on the result.
- R8: Size code 00 with the lane-split flag set places the code for input bits 63..32 in result bits 35..32 and the code for bits 31..0 in result bits 3..0.
- R9: Size codes 10 and 11 give an all-zero result and set illegalSize. Codes 00 and 01 clear illegalSize.
- R10: With the output register present (the default), the result and flag appear one clock after the inputs. An active-low reset clears both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low synchronous reset |
| opIn | input | 64 | Operand word to classify |
| sizeCode | input | 2 | 00 single, 01 double, 1x reserved |
| simdEn | input | 1 | Classify both 32-bit halves in single mode |
| resOut | output | 64 | Zero-extended per-lane type codes |
| illegalSize | output | 1 | Reserved size code was presented |

## Verification
Every sign and class pair is presented in both precisions: signed zeros, denormals at the smallest and largest mantissa, infinities, quiet and signalling NaNs, and normals at both ends of the exponent range. These patterns separate each exponent decode and the mantissa test from the sign tap. Single-precision vectors carry nonzero upper halves, which exposes any leakage from the wrong lane in scalar mode. Lane-split vectors pair a different class in each half, which catches swapped or merged lanes. Reserved size codes are driven together with operands that would otherwise give nonzero codes.

// File: rtl/fpClassPkg.sv
package fpClassPkg;
  localparam int OP_W   = 64;
  localparam int CODE_W = 4;
  localparam int HALF_W = OP_W / 2;
  localparam int DBL_EXP_W = 11;
  localparam int DBL_MAN_W = 52;
  localparam int SGL_EXP_W = 8;
  localparam int SGL_MAN_W = 23;

  localparam logic [1:0] SIZE_SINGLE = 2'b00;
  localparam logic [1:0] SIZE_DOUBLE = 2'b01;

  typedef struct packed {
    logic selDouble;
    logic selSingleLo;
    logic selSingleHi;
    logic flagIllegal;
  } laneStrobe_t;
endpackage

// File: rtl/fpLaneClass.sv
module fpLaneClass #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  localparam int VAL_W = EXP_W + MAN_W + 1
) (
  input  logic [VAL_W-1:0] laneVal,
  output logic [3:0]       laneCode
);
  logic             signBit;
  logic [EXP_W-1:0] expField;
  logic [MAN_W-1:0] manField;
  logic [1:0]       expClass;

  assign signBit  = laneVal[VAL_W-1];
  assign expField = laneVal[MAN_W +: EXP_W];
  assign manField = laneVal[MAN_W-1:0];

  // 00 all zeros, 01 all ones, 10 anything else (sub-class bit held at 0)
  always_comb begin
    if (expField == '0)       expClass = 2'b00;
    else if (&expField)       expClass = 2'b01;
    else                      expClass = 2'b10;
  end

  assign laneCode = {expClass, |manField, signBit};
endmodule

// File: rtl/fpClassCtrl.sv
module fpClassCtrl
  import fpClassPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  sizeCode,
  input  logic        simdEn,
  output laneStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    case (sizeCode)
      SIZE_SINGLE: begin
        strobe.selSingleLo = 1'b1;
        strobe.selSingleHi = simdEn;
      end
      SIZE_DOUBLE: strobe.selDouble = 1'b1;
      default:     strobe.flagIllegal = 1'b1;
    endcase
  end

  assert_illegal_no_lane_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flagIllegal |-> !(strobe.selDouble || strobe.selSingleLo || strobe.selSingleHi));
  assert_hi_lane_pairs_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.selSingleHi |-> (strobe.selSingleLo && !strobe.selDouble));
endmodule

// File: rtl/fpClassDatapath.sv
module fpClassDatapath
  import fpClassPkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] opIn,
  input  laneStrobe_t     strobe,
  output logic [OP_W-1:0] resOut,
  output logic            illegalSize
);
  logic [CODE_W-1:0] dblCode, loCode, hiCode;
  logic [OP_W-1:0]   nextRes;

  fpLaneClass #(.EXP_W(DBL_EXP_W), .MAN_W(DBL_MAN_W)) uDbl (
    .laneVal(opIn), .laneCode(dblCode));
  fpLaneClass #(.EXP_W(SGL_EXP_W), .MAN_W(SGL_MAN_W)) uLo (
    .laneVal(opIn[HALF_W-1:0]), .laneCode(loCode));
  fpLaneClass #(.EXP_W(SGL_EXP_W), .MAN_W(SGL_MAN_W)) uHi (
    .laneVal(opIn[OP_W-1:HALF_W]), .laneCode(hiCode));

  always_comb begin
    nextRes = '0;
    if (strobe.selDouble)   nextRes[CODE_W-1:0] = dblCode;
    if (strobe.selSingleLo) nextRes[CODE_W-1:0] = loCode;
    if (strobe.selSingleHi) nextRes[HALF_W +: CODE_W] = hiCode;
  end

  generate
    if (REG_OUT) begin : gReg
      logic primed;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          resOut      <= '0;
          illegalSize <= 1'b0;
          primed      <= 1'b0;
        end else begin
          resOut      <= nextRes;
          illegalSize <= strobe.flagIllegal;
          primed      <= 1'b1;
        end
      end

      assert_sign_tap_R1: assert property (@(posedge clk) disable iff (!rstN)
        (primed && $past(strobe.selDouble)) |-> (resOut[0] == $past(opIn[63])));
      assert_mant_flag_R2: assert property (@(posedge clk) disable iff (!rstN)
        (primed && $past(strobe.selSingleLo)) |-> (resOut[1] == $past(|opIn[22:0])));
      assert_exp_ones_R3: assert property (@(posedge clk) disable iff (!rstN)
        (primed && $past(strobe.selDouble) && $past(&opIn[62:52])) |-> (resOut[3:2] == 2'b01));
      assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
        (resOut[63:36] == '0) && (resOut[31:4] == '0));
      assert_illegal_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
        illegalSize |-> (resOut == '0));
    end else begin : gComb
      assign resOut      = nextRes;
      assign illegalSize = strobe.flagIllegal;
    end
  endgenerate
endmodule

// File: rtl/fpClassTester.sv
module fpClassTester
  import fpClassPkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [63:0] opIn,
  input  logic [1:0]  sizeCode,
  input  logic        simdEn,
  output logic [63:0] resOut,
  output logic        illegalSize
);
  laneStrobe_t strobe;

  fpClassCtrl uCtrl (
    .clk(clk), .rstN(rstN), .sizeCode(sizeCode), .simdEn(simdEn), .strobe(strobe));

  fpClassDatapath #(.REG_OUT(REG_OUT)) uPath (
    .clk(clk), .rstN(rstN), .opIn(opIn), .strobe(strobe),
    .resOut(resOut), .illegalSize(illegalSize));
endmodule

// File: tb/tb_fpClassTester.sv
module tb_fpClassTester;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] opIn = '0;
  logic [1:0]  sizeCode = 2'b01;
  logic        simdEn = 1'b0;
  logic [63:0] resOut;
  logic        illegalSize;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fpClassTester dut (.*);

  localparam int NV = 30;
  // operand, size, simd, expected result, expected flag, requirement tag
  localparam logic [63:0] V_OP [NV] = '{
    64'h0000000000000000, 64'h8000000000000000, 64'h0000000000000001, 64'h800FFFFFFFFFFFFF,
    64'h7FF0000000000000, 64'hFFF0000000000000, 64'h7FF8000000000000, 64'hFFF0000000000001,
    64'h3FF0000000000000, 64'hC000000000000001, 64'h7FEFFFFFFFFFFFFF, 64'h4000000000000000,
    64'hFFFFFFFF00000000, 64'h0000000080000000, 64'hAAAAAAAA7F800000, 64'h12345678FF800000,
    64'h000000007FC00000, 64'h00000000FF800001, 64'h0000000000000001, 64'h00000000807FFFFF,
    64'h000000003F800000, 64'hFFFFFFFFBF800001, 64'h0000000000800000, 64'h7F80000080000001,
    64'hFFC0000040490FDB, 64'h0000000000000000, 64'h800000007F800001, 64'h7F7FFFFF00000000,
    64'h3FF0000000000000, 64'h7F80000080000001};
  localparam logic [1:0] V_SZ [NV] = '{
    2'b01,2'b01,2'b01,2'b01,2'b01,2'b01,2'b01,2'b01,2'b01,2'b01,2'b01,2'b01,
    2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,
    2'b00,2'b00,2'b00,2'b00,2'b00,2'b10,2'b11};
  localparam logic V_SIMD [NV] = '{
    0,0,0,0,0,0,0,0,0,0,0,1, 0,0,0,0,0,0,0,0,0,0,0, 1,1,1,1,1,0,1};
  localparam logic [63:0] V_EXP [NV] = '{
    64'h0, 64'h1, 64'h2, 64'h3, 64'h4, 64'h5, 64'h6, 64'h7, 64'h8, 64'hB, 64'hA, 64'h8,
    64'h0, 64'h1, 64'h4, 64'h5, 64'h6, 64'h7, 64'h2, 64'h3, 64'h8, 64'hB, 64'h8,
    64'h0000000400000003, 64'h000000070000000A, 64'h0, 64'h0000000100000006,
    64'h0000000A00000000, 64'h0, 64'h0};
  localparam logic V_ILL [NV] = '{
    0,0,0,0,0,0,0,0,0,0,0,0, 0,0,0,0,0,0,0,0,0,0,0, 0,0,0,0,0,1,1};
  localparam string V_TAG [NV] = '{
    "R3","R1","R2","R2","R3","R1","R3","R2","R4","R4","R4","R6",
    "R7","R1","R7","R7","R3","R2","R2","R2","R4","R7","R4",
    "R8","R8","R8","R8","R5","R9","R9"};

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    opIn = 64'h7FF0000000000000;
    sizeCode = 2'b10;
    repeat (3) @(negedge clk);
    check("R10 reset result", resOut, 64'h0);
    check("R10 reset flag", {63'b0, illegalSize}, 64'h0);
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      opIn = V_OP[i];
      sizeCode = V_SZ[i];
      simdEn = V_SIMD[i];
      @(negedge clk);
      check({V_TAG[i], " vector result"}, resOut, V_EXP[i]);
      check("R9 flag", {63'b0, illegalSize}, {63'b0, V_ILL[i]});
    end
    // R10: one-cycle latency, output holds until the edge
    opIn = 64'hFFF0000000000000;
    sizeCode = 2'b01;
    simdEn = 1'b0;
    @(negedge clk);
    check("R10 settled", resOut, 64'h5);
    opIn = 64'h7FF8000000000000;
    #2;
    check("R10 holds before edge", resOut, 64'h5);
    @(negedge clk);
    check("R10 after edge", resOut, 64'h6);
    // R7: upper half varies, result unchanged
    sizeCode = 2'b00;
    opIn = 64'h7FF0000080000000;
    @(negedge clk);
    check("R7 upper ignored a", resOut, 64'h1);
    opIn = 64'h0000000180000000;
    @(negedge clk);
    check("R7 upper ignored b", resOut, 64'h1);
    // R9 then legal again clears flag
    sizeCode = 2'b11;
    @(negedge clk);
    check("R9 illegal zero", resOut, 64'h0);
    check("R9 illegal flag", {63'b0, illegalSize}, 64'h1);
    sizeCode = 2'b01;
    @(negedge clk);
    check("R9 flag clears", {63'b0, illegalSize}, 64'h0);
    // R10: reset mid-run clears outputs
    rstN = 1'b0;
    @(negedge clk);
    check("R10 reset clears", resOut, 64'h0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule